// File: doc/BRIEF.md
# SCSI Attention and Parity Controller

This block owns the attention line and received-byte parity checking for a narrow (8-bit) SCSI bus port. It watches the REQ/ACK handshake, tests every byte latched on a rising ACK for odd parity, records errors in a sticky status bit and raises an interrupt through a mask. In the initiator role it drives ATN in two cases. The first is during a selection, when the initiator has a message to send. The second is after a bad byte, when automatic attention is enabled. It also holds the port's current role (initiator or target) and defers role changes that arrive while the port is connected.

Selection, phase decoding and the transfer engine are outside the block and reach it only as single-cycle event pulses and a connection level. The block drives its own SEL output so that ATN and SEL can be released together on a selection timeout. The byte path is the bus's own REQ/ACK handshake. The block only observes it and never stalls it, and a parity error never stops the transfer. There is therefore no valid/ready interface and no back-pressure, and every other pin is a plain level or strobe.

Top module: `scsi_atn_parity_ctrl`

## Requirements
- R1: After reset, ATN, SEL, the parity status bit and the interrupt are 0, and the role is initiator (is_target = 0).
- R2: A sel_go pulse sets SEL on the next clock. If cfg_sel_atn is 1 and the role is initiator, ATN rises on that same clock and stays high throughout the selection.
- R3: A sel_tmo pulse during a selection clears SEL and any selection-driven ATN on the same clock edge.
- R4: With cfg_sel_atn at 0, or with the role set to target, a selection leaves ATN at 0.
- R5: A byte is checked when bus_ack rises while bus_req is high. The byte is in error when bus_data together with bus_par holds an even number of ones. With cfg_par_chk at 1 an error sets perr_stat on the next clock. This works in both roles.
- R6: With cfg_par_chk at 0, a received byte never sets perr_stat, whatever its parity.
- R7: Automatic ATN on a bad byte needs cfg_par_chk = 1, cfg_atn_on_err = 1 and the initiator role together. If any of these is missing, ATN stays 0.
- R8: On an errored byte that qualifies for automatic ATN, ATN is high in the same cycle that ACK rises for that byte. ATN is therefore up before ACK falls. It stays high until a phase_chg pulse.
- R9: perr_stat stays set through later good bytes and clears on the clock after a perr_clr pulse. A new error in the same cycle as perr_clr wins, and the bit stays set.
- R10: irq_o equals perr_stat AND irq_mask.
- R11: A role write (role_wr with role_wr_val, 1 = target) takes effect on the next clock while link_up is 0. A write made while link_up is 1 is held and applies on the first clock with link_up at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel_atn | input | 1 | Assert ATN during selection |
| cfg_par_chk | input | 1 | Enable received-byte parity checking |
| cfg_atn_on_err | input | 1 | Assert ATN automatically on a parity error |
| role_wr | input | 1 | Role write strobe |
| role_wr_val | input | 1 | Role to write, 1 = target |
| link_up | input | 1 | Port is connected to the bus |
| sel_go | input | 1 | Selection start pulse |
| sel_tmo | input | 1 | Selection timeout pulse |
| phase_chg | input | 1 | Bus phase change pulse |
| bus_data | input | 8 | SCSI data bus |
| bus_par | input | 1 | SCSI data parity bit |
| bus_req | input | 1 | REQ handshake line |
| bus_ack | input | 1 | ACK handshake line |
| perr_clr | input | 1 | Clear strobe for the parity status bit |
| irq_mask | input | 1 | Interrupt enable for parity errors |
| atn_o | output | 1 | ATN line |
| sel_o | output | 1 | SEL line |
| perr_stat | output | 1 | Sticky parity error status |
| irq_o | output | 1 | Interrupt request |
| is_target | output | 1 | Current role, 1 = target |

## Verification
Some properties are checked on every cycle. ATN must be high in any cycle that qualifies a bad byte and in the cycle after. A timeout must drop SEL and ATN together. Disabled checking must never set the status bit. The role must hold steady while connected. The bench scenarios cover the rest: the full matrix of enable bits, role and parity polarity, deferring a role write across a disconnect, clear-versus-set collisions, and the interrupt mask.

// File: rtl/scsi_atn_pkg.sv
package scsi_atn_pkg;
  typedef enum logic {ROLE_INIT = 1'b0, ROLE_TGT = 1'b1} role_e;
  parameter int BUS_W = 8;
endpackage

// File: rtl/scsi_par_check.sv
module scsi_par_check #(
  parameter int DW  = 8,
  parameter bit ODD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic [DW-1:0] data,
  input  logic          par,
  input  logic          req,
  input  logic          ack,
  input  logic          clr,
  output logic          hit,
  output logic          stat
);
  localparam int TOT_W = DW + 1;
  logic [TOT_W-1:0] word;
  logic ack_q, ack_rise, bad;

  assign word = {par, data};

  generate
    if (ODD) begin : g_odd
      assign bad = ~(^word);
    end else begin : g_even
      assign bad = ^word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack;
  end

  assign ack_rise = ack && !ack_q && req;
  assign hit      = ack_rise && chk_en && bad;

  always_ff @(posedge clk) begin
    if (!rst_n)   stat <= 1'b0;
    else if (hit) stat <= 1'b1;
    else if (clr) stat <= 1'b0;
  end

  assert_no_report_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(chk_en) && !$past(stat)) |-> !stat);
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat);
endmodule

// File: rtl/scsi_role_ctrl.sv
module scsi_role_ctrl
  import scsi_atn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  logic  wr_val,
  input  logic  link,
  output role_e role
);
  logic  pend_v;
  role_e pend_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role   <= ROLE_INIT;
      pend_v <= 1'b0;
      pend_r <= ROLE_INIT;
    end else if (wr) begin
      if (!link) begin
        role   <= role_e'(wr_val);
        pend_v <= 1'b0;
      end else begin
        pend_v <= 1'b1;
        pend_r <= role_e'(wr_val);
      end
    end else if (!link && pend_v) begin
      role   <= pend_r;
      pend_v <= 1'b0;
    end
  end

  assert_role_hold_linked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(link) |-> $stable(role));
endmodule

// File: rtl/scsi_atn_ctrl.sv
module scsi_atn_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_sel_atn,
  input  logic cfg_auto,
  input  logic initiator,
  input  logic link,
  input  logic sel_go,
  input  logic sel_tmo,
  input  logic phase_chg,
  input  logic err_hit,
  output logic atn,
  output logic sel
);
  logic sel_atn_q, err_atn_q, err_now;

  assign err_now = err_hit && cfg_auto && initiator;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel       <= 1'b0;
      sel_atn_q <= 1'b0;
    end else if (sel_go) begin
      sel       <= 1'b1;
      sel_atn_q <= cfg_sel_atn && initiator;
    end else if (sel_tmo) begin
      sel       <= 1'b0;
      sel_atn_q <= 1'b0;
    end else begin
      if (link)      sel       <= 1'b0;
      if (phase_chg) sel_atn_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         err_atn_q <= 1'b0;
    else if (err_now)   err_atn_q <= 1'b1;
    else if (phase_chg) err_atn_q <= 1'b0;
  end

  assign atn = sel_atn_q || err_atn_q || err_now;

  assert_atn_on_bad_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_now |-> atn);
  assert_atn_held_after_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_now |=> atn);
  assert_tmo_drops_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tmo && !sel_go && sel && !err_atn_q && !err_now) |=> (!sel && !atn));
  assert_sel_atn_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_go && cfg_sel_atn && initiator) |=> (atn && sel));
endmodule

// File: rtl/scsi_atn_parity_ctrl.sv
module scsi_atn_parity_ctrl
  import scsi_atn_pkg::*;
#(
  parameter int DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel_atn,
  input  logic              cfg_par_chk,
  input  logic              cfg_atn_on_err,
  input  logic              role_wr,
  input  logic              role_wr_val,
  input  logic              link_up,
  input  logic              sel_go,
  input  logic              sel_tmo,
  input  logic              phase_chg,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_par,
  input  logic              bus_req,
  input  logic              bus_ack,
  input  logic              perr_clr,
  input  logic              irq_mask,
  output logic              atn_o,
  output logic              sel_o,
  output logic              perr_stat,
  output logic              irq_o,
  output logic              is_target
);
  role_e role;
  logic  err_hit;

  scsi_par_check #(.DW(DATA_W), .ODD(1'b1)) u_par (
    .clk(clk), .rst_n(rst_n), .chk_en(cfg_par_chk),
    .data(bus_data), .par(bus_par), .req(bus_req), .ack(bus_ack),
    .clr(perr_clr), .hit(err_hit), .stat(perr_stat)
  );

  scsi_role_ctrl u_role (
    .clk(clk), .rst_n(rst_n), .wr(role_wr), .wr_val(role_wr_val),
    .link(link_up), .role(role)
  );

  scsi_atn_ctrl u_atn (
    .clk(clk), .rst_n(rst_n), .cfg_sel_atn(cfg_sel_atn),
    .cfg_auto(cfg_atn_on_err && cfg_par_chk), .initiator(role == ROLE_INIT),
    .link(link_up), .sel_go(sel_go), .sel_tmo(sel_tmo),
    .phase_chg(phase_chg), .err_hit(err_hit), .atn(atn_o), .sel(sel_o)
  );

  assign is_target = (role == ROLE_TGT);
  assign irq_o     = perr_stat && irq_mask;

  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq_o);
endmodule

// File: tb/scsi_atn_parity_ctrl_bench.sv
module scsi_atn_parity_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sel_atn = 0, cfg_par_chk = 0, cfg_atn_on_err = 0;
  logic role_wr = 0, role_wr_val = 0, link_up = 0;
  logic sel_go = 0, sel_tmo = 0, phase_chg = 0;
  logic [7:0] bus_data = 0;
  logic bus_par = 0, bus_req = 0, bus_ack = 0, perr_clr = 0, irq_mask = 0;
  logic atn_o, sel_o, perr_stat, irq_o, is_target;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scsi_atn_parity_ctrl u_scsi_atn_parity_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_sel_atn(cfg_sel_atn), .cfg_par_chk(cfg_par_chk),
    .cfg_atn_on_err(cfg_atn_on_err), .role_wr(role_wr), .role_wr_val(role_wr_val),
    .link_up(link_up), .sel_go(sel_go), .sel_tmo(sel_tmo), .phase_chg(phase_chg),
    .bus_data(bus_data), .bus_par(bus_par), .bus_req(bus_req), .bus_ack(bus_ack),
    .perr_clr(perr_clr), .irq_mask(irq_mask), .atn_o(atn_o), .sel_o(sel_o),
    .perr_stat(perr_stat), .irq_o(irq_o), .is_target(is_target)
  );

  // entry: {data[7:0], par, chk_en, auto_en, target, exp_stat, exp_atn}
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // good byte
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // bad, auto ATN
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // check off
    {8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // bad, auto off
    {8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // bad, target role
    {8'h7F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // good, target
    {8'h80, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // good
    {8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}   // bad, all ones
  };

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic p);
    bus_data = d; bus_par = p; bus_req = 1; bus_ack = 1;
    #1;
  endtask

  task automatic end_byte();
    tick();
    bus_ack = 0; bus_req = 0;
    #1;
  endtask

  task automatic set_role(input logic t);
    role_wr = 1; role_wr_val = t;
    tick();
    role_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    // R1 reset state
    chk("R1 atn", atn_o, 0); chk("R1 sel", sel_o, 0);
    chk("R1 stat", perr_stat, 0); chk("R1 irq", irq_o, 0);
    chk("R1 role", is_target, 0);
    rst_n = 1;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      cfg_par_chk = v[4]; cfg_atn_on_err = v[3];
      role_wr = 1; role_wr_val = v[2]; phase_chg = 1; perr_clr = 1;
      tick();
      role_wr = 0; phase_chg = 0; perr_clr = 0;
      send_byte(v[13:6], v[5]);
      chk("R8 atn same cycle as ack", atn_o, v[0]);
      end_byte();
      chk("R5/R6 status", perr_stat, v[1]);
      chk("R7 atn after ack", atn_o, v[0]);
      tick();
      chk("R8 atn held", atn_o, v[0]);
    end
    phase_chg = 1; tick(); phase_chg = 0;
    chk("R8 atn dropped by phase", atn_o, 0);

    // R2/R3 selection with attention then timeout
    perr_clr = 1; tick(); perr_clr = 0;
    set_role(0);
    cfg_sel_atn = 1; sel_go = 1; tick(); sel_go = 0;
    chk("R2 sel", sel_o, 1); chk("R2 atn", atn_o, 1);
    tick(); tick();
    chk("R2 atn held", atn_o, 1);
    sel_tmo = 1; tick(); sel_tmo = 0;
    chk("R3 sel off", sel_o, 0); chk("R3 atn off", atn_o, 0);

    // R4 no attention request
    cfg_sel_atn = 0; sel_go = 1; tick(); sel_go = 0;
    chk("R4 sel", sel_o, 1); chk("R4 atn clear cfg", atn_o, 0);
    sel_tmo = 1; tick(); sel_tmo = 0;
    set_role(1);
    cfg_sel_atn = 1; sel_go = 1; tick(); sel_go = 0;
    chk("R4 atn target", atn_o, 0);
    sel_tmo = 1; tick(); sel_tmo = 0;

    // R10 irq mask, R9 sticky and clear
    cfg_par_chk = 1; cfg_atn_on_err = 0; irq_mask = 0;
    send_byte(8'h01, 1'b1); end_byte();
    chk("R5 target role check", perr_stat, 1);
    chk("R10 masked", irq_o, 0);
    irq_mask = 1; #1;
    chk("R10 unmasked", irq_o, 1);
    send_byte(8'h01, 1'b0); end_byte();
    chk("R9 sticky through good byte", perr_stat, 1);
    perr_clr = 1; tick(); perr_clr = 0;
    chk("R9 cleared", perr_stat, 0);
    chk("R10 irq cleared", irq_o, 0);
    perr_clr = 1; send_byte(8'h11, 1'b0); end_byte(); perr_clr = 0;
    chk("R9 set wins over clear", perr_stat, 1);

    // R11 role deferral
    set_role(0);
    chk("R11 immediate", is_target, 0);
    link_up = 1; set_role(1);
    chk("R11 held while linked", is_target, 0);
    tick();
    chk("R11 still held", is_target, 0);
    link_up = 0; tick();
    chk("R11 applied on disconnect", is_target, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule